// File: doc/BRIEF.md
# Prioritized Bus Master Arbiter

This block decides which of four masters owns a shared memory bus: an external requester, two DMA channels and the processor core. Each master raises a request line. The current owner reports the end of each of its bus cycles, whether that cycle finishes an operand, and whether it is the read half of a read-modify-write pair. The arbiter holds a one-hot grant register and moves the grant only at points where the owner may safely let go of the bus.

The external requester always wins. The DMA channels come next and the core comes last. Between the two DMA channels, a programmable level per channel sets the order. Raw DMA requests pass through a synchronizer chain before they can take part in arbitration, so a late request does not steal a cycle that is about to start. When the two levels are programmed equal, a configuration flag rises and both channels are treated as idle until the levels differ again.

When nobody requests, the grant stays parked with the last owner.

Top module: `bus_master_arbiter`

## Requirements
- R1: The grant is always one-hot. Bit 0 is the external master, bit 1 is DMA channel 0, bit 2 is DMA channel 1 and bit 3 is the core. Synchronous reset gives the grant to the core.
- R2: At an arbitration point, a pending external request takes the grant ahead of every other request.
- R3: While the owner is requesting, a cycle end with `last_of_operand` low leaves the grant unchanged.
- R4: While the owner is requesting, a cycle end with `rmw_read` high leaves the grant unchanged, even when `last_of_operand` is high.
- R5: A DMA request first sampled high on clock edge n is not seen at an arbitration point on edges before n+SYNC_STAGES. It is seen on edge n+SYNC_STAGES and later.
- R6: When both DMA channels are eligible, the channel with the numerically larger level is granted. Any eligible DMA channel wins over the core.
- R7: When the two DMA levels are equal, `cfg_err` is high and both DMA requests are ignored. When the levels differ, `cfg_err` is low.
- R8: The grant changes only on the clock edge that samples an arbitration point. An arbitration point is either a cycle end with `last_of_operand` high and `rmw_read` low, or any cycle in which the owner is not requesting. If no request is pending at that point, the grant stays with the current owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_req | input | 1 | External master request |
| dma_req | input | 2 | Raw DMA channel requests (bit 0 = channel 0); these are synchronized inside the block |
| dma_lvl0 | input | LVL_W | Priority level of DMA channel 0 |
| dma_lvl1 | input | LVL_W | Priority level of DMA channel 1 |
| cpu_req | input | 1 | Core request |
| cycle_done | input | 1 | The owner's current bus cycle ends in this clock |
| last_of_operand | input | 1 | The ending cycle is the final cycle of its operand |
| rmw_read | input | 1 | The ending cycle is the read half of a read-modify-write pair |
| grant | output | 4 | One-hot bus grant |
| cfg_err | output | 1 | The two DMA levels are equal |

## Verification
The bench builds the block with SYNC_STAGES=2 and LVL_W=3. With two synchronizer stages, the test can pin the DMA request to one exact edge and check both the edge that must still miss it and the edge that must first see it. A three-bit level lets the bench program both channel orders and also the equal-level error case, and it can reprogram the levels while a DMA channel already owns the bus.

// File: rtl/busarb_pkg.sv
package busarb_pkg;

    localparam int NUM_DMA = 2;
    localparam int NUM_MST = NUM_DMA + 2;

    typedef enum logic [1:0] {
        M_EXT  = 2'd0,
        M_DMA0 = 2'd1,
        M_DMA1 = 2'd2,
        M_CPU  = 2'd3
    } mst_e;

    typedef logic [NUM_MST-1:0] mvec_t;

    function automatic mvec_t to_onehot(mst_e m);
        return mvec_t'(1) << m;
    endfunction

endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] sh;
        always_ff @(posedge clk) begin
            if (rst) sh <= '0;
            else     sh <= STAGES'({sh, din[g]});
        end
        assign dout[g] = sh[STAGES-1];
    end

endmodule

// File: rtl/dma_level_cmp.sv
module dma_level_cmp #(
    parameter int LVL_W = 3
) (
    input  logic [LVL_W-1:0] lvl0,
    input  logic [LVL_W-1:0] lvl1,
    output logic             cfg_err,
    output logic             dma1_first
);

    always_comb begin
        cfg_err    = (lvl0 == lvl1);
        dma1_first = (lvl1 > lvl0);
    end

endmodule

// File: rtl/arb_pick.sv
module arb_pick
    import busarb_pkg::*;
(
    input  mvec_t pend,
    input  logic  dma1_first,
    output mst_e  pick,
    output logic  any
);

    always_comb begin
        any  = |pend;
        pick = M_CPU;
        if (pend[M_EXT])                     pick = M_EXT;
        else if (dma1_first && pend[M_DMA1]) pick = M_DMA1;
        else if (pend[M_DMA0])               pick = M_DMA0;
        else if (pend[M_DMA1])               pick = M_DMA1;
        else if (pend[M_CPU])                pick = M_CPU;
    end

endmodule

// File: rtl/bus_master_arbiter.sv
module bus_master_arbiter
    import busarb_pkg::*;
#(
    parameter int LVL_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ext_req,
    input  logic [1:0]         dma_req,
    input  logic [LVL_W-1:0]   dma_lvl0,
    input  logic [LVL_W-1:0]   dma_lvl1,
    input  logic               cpu_req,
    input  logic               cycle_done,
    input  logic               last_of_operand,
    input  logic               rmw_read,
    output logic [3:0]         grant,
    output logic               cfg_err
);

    logic [NUM_DMA-1:0] dma_sync;
    logic [NUM_DMA-1:0] dma_ok;
    logic               dma1_first;
    mvec_t              pend;
    mvec_t              grant_q;
    mst_e               pick;
    logic               any_pend;
    logic               owner_req;
    logic               arb_point;

    dma_req_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (NUM_DMA)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (dma_req),
        .dout (dma_sync)
    );

    dma_level_cmp #(
        .LVL_W (LVL_W)
    ) u_lvl (
        .lvl0       (dma_lvl0),
        .lvl1       (dma_lvl1),
        .cfg_err    (cfg_err),
        .dma1_first (dma1_first)
    );

    always_comb begin
        dma_ok    = dma_sync & {NUM_DMA{~cfg_err}};
        pend      = {cpu_req, dma_ok[1], dma_ok[0], ext_req};
        owner_req = |(grant_q & pend);
        arb_point = (cycle_done & last_of_operand & ~rmw_read) | ~owner_req;
    end

    arb_pick u_pick (
        .pend       (pend),
        .dma1_first (dma1_first),
        .pick       (pick),
        .any        (any_pend)
    );

    always_ff @(posedge clk) begin
        if (rst)                        grant_q <= to_onehot(M_CPU);
        else if (arb_point && any_pend) grant_q <= to_onehot(pick);
    end

    assign grant = grant_q;

endmodule

// File: rtl/busarb_checker.sv
module busarb_checker (
    input logic       clk,
    input logic       rst,
    input logic       ext_req,
    input logic       cycle_done,
    input logic       last_of_operand,
    input logic       rmw_read,
    input logic       owner_busy,
    input logic       cfg_err,
    input logic [3:0] grant
);

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(grant) == 1); // R1

    AST_EXT_FIRST: assert property (@(posedge clk) disable iff (rst)
        cycle_done && last_of_operand && !rmw_read && ext_req |=> grant[0]); // R2

    AST_HOLD_MID_OPERAND: assert property (@(posedge clk) disable iff (rst)
        owner_busy && cycle_done && !last_of_operand |=> $stable(grant)); // R3

    AST_RMW_ATOMIC: assert property (@(posedge clk) disable iff (rst)
        owner_busy && cycle_done && rmw_read |=> $stable(grant)); // R4

    AST_CFG_MASKS_DMA: assert property (@(posedge clk) disable iff (rst)
        cfg_err && grant[2:1] == 2'b00 |=> grant[2:1] == 2'b00); // R7

    AST_HOLD_BETWEEN_POINTS: assert property (@(posedge clk) disable iff (rst)
        owner_busy && !cycle_done |=> $stable(grant)); // R8

endmodule

bind bus_master_arbiter busarb_checker i_chk (
    .clk             (clk),
    .rst             (rst),
    .ext_req         (ext_req),
    .cycle_done      (cycle_done),
    .last_of_operand (last_of_operand),
    .rmw_read        (rmw_read),
    .owner_busy      (owner_req),
    .cfg_err         (cfg_err),
    .grant           (grant)
);

// File: tb/test_bus_master_arbiter.sv
module test_bus_master_arbiter;

    localparam int LVL_W = 3;
    localparam logic [3:0] G_EXT  = 4'b0001;
    localparam logic [3:0] G_DMA0 = 4'b0010;
    localparam logic [3:0] G_DMA1 = 4'b0100;
    localparam logic [3:0] G_CPU  = 4'b1000;

    logic             clk = 1'b0;
    logic             rst;
    logic             ext_req;
    logic [1:0]       dma_req;
    logic [LVL_W-1:0] dma_lvl0;
    logic [LVL_W-1:0] dma_lvl1;
    logic             cpu_req;
    logic             cycle_done;
    logic             last_of_operand;
    logic             rmw_read;
    logic [3:0]       grant;
    logic             cfg_err;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #2 clk = ~clk;

    bus_master_arbiter #(.LVL_W(LVL_W), .SYNC_STAGES(2)) i_bus_master_arbiter (
        .clk             (clk),
        .rst             (rst),
        .ext_req         (ext_req),
        .dma_req         (dma_req),
        .dma_lvl0        (dma_lvl0),
        .dma_lvl1        (dma_lvl1),
        .cpu_req         (cpu_req),
        .cycle_done      (cycle_done),
        .last_of_operand (last_of_operand),
        .rmw_read        (rmw_read),
        .grant           (grant),
        .cfg_err         (cfg_err)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input logic [3:0] exp, input string tag);
        n_cmp++;
        if (grant !== exp) begin
            n_bad++;
            $display("FAIL %s: grant=%b expected=%b", tag, grant, exp);
        end
    endtask

    task automatic chk_err(input logic exp, input string tag);
        n_cmp++;
        if (cfg_err !== exp) begin
            n_bad++;
            $display("FAIL %s: cfg_err=%b expected=%b", tag, cfg_err, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        ext_req = 1'b0; dma_req = 2'b00; cpu_req = 1'b0;
        cycle_done = 1'b0; last_of_operand = 1'b0; rmw_read = 1'b0;
        dma_lvl0 = 3'd1; dma_lvl1 = 3'd2;
        repeat (2) step();
        rst = 1'b0;
        step();
    endtask

    task automatic end_cycle(input logic last, input logic rmw);
        cycle_done = 1'b1; last_of_operand = last; rmw_read = rmw;
        step();
        cycle_done = 1'b0; last_of_operand = 1'b0; rmw_read = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk(G_CPU, "R1 reset grant");
        chk_err(1'b0, "R7 reset levels differ");
    endtask

    task automatic t_ext_priority();
        do_reset();
        cpu_req = 1'b1;
        step();
        ext_req = 1'b1; dma_req = 2'b11;
        repeat (4) step();
        chk(G_CPU, "R8 no change without cycle end");
        end_cycle(1'b0, 1'b0);
        chk(G_CPU, "R3 mid operand hold");
        end_cycle(1'b1, 1'b0);
        chk(G_EXT, "R2 external wins over DMA and core");
    endtask

    task automatic t_rmw();
        do_reset();
        cpu_req = 1'b1; ext_req = 1'b1;
        step();
        end_cycle(1'b1, 1'b1);
        chk(G_CPU, "R4 rmw read end holds");
        end_cycle(1'b1, 1'b0);
        chk(G_EXT, "R4 rmw write end releases");
    endtask

    task automatic t_dma_latency();
        do_reset();
        cpu_req = 1'b1;
        step();
        dma_req = 2'b01;
        step();
        cycle_done = 1'b1; last_of_operand = 1'b1;
        step();
        chk(G_CPU, "R5 DMA not yet synchronized");
        step();
        cycle_done = 1'b0; last_of_operand = 1'b0;
        chk(G_DMA0, "R5 DMA seen after sync stages");
    endtask

    task automatic t_dma_order();
        do_reset();
        cpu_req = 1'b1; dma_req = 2'b11;
        repeat (3) step();
        end_cycle(1'b1, 1'b0);
        chk(G_DMA1, "R6 larger level channel 1 wins");
        dma_lvl0 = 3'd5;
        end_cycle(1'b1, 1'b0);
        chk(G_DMA0, "R6 larger level channel 0 wins");
    endtask

    task automatic t_cfg_err();
        do_reset();
        dma_lvl0 = 3'd3; dma_lvl1 = 3'd3;
        #0;
        chk_err(1'b1, "R7 equal levels flagged");
        cpu_req = 1'b1; dma_req = 2'b11;
        repeat (3) step();
        end_cycle(1'b1, 1'b0);
        chk(G_CPU, "R7 DMA ignored under error");
        cpu_req = 1'b0;
        step();
        chk(G_CPU, "R7 idle owner parked, DMA still ignored");
        dma_lvl1 = 3'd4;
        step();
        chk_err(1'b0, "R7 error cleared");
        chk(G_DMA1, "R7 DMA eligible after fix");
    endtask

    task automatic t_park();
        do_reset();
        cpu_req = 1'b1; ext_req = 1'b1;
        step();
        end_cycle(1'b1, 1'b0);
        chk(G_EXT, "R2 external granted");
        ext_req = 1'b0; cpu_req = 1'b0;
        repeat (2) step();
        chk(G_EXT, "R8 parked with last owner");
        cpu_req = 1'b1;
        step();
        chk(G_CPU, "R8 idle owner hands over");
    endtask

    initial begin
        t_reset();
        t_ext_priority();
        t_rmw();
        t_dma_latency();
        t_dma_order();
        t_cfg_err();
        t_park();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule